// File: doc/BRIEF.md
# Interrupt Router with Per-Source IRQ/FIQ Steering

This block collects a vector of level-sensitive interrupt lines from peripherals and turns them into the two exception requests of a processor core. One is the normal request (IRQ) and the other is the fast request (FIQ). Software sets a routing register that sends each source to one of the two outputs. It also sets an enable register that decides which sources may raise a request at all. Both registers, along with three pending views, sit on a small memory-mapped register bus.

The source lines are sampled once per clock. The pending state follows the lines and is cleared only by the peripheral that drives them; a write to this block never clears it. A separate wake output serves the power-mode sequencer while the core is idle. A control bit selects which sources may end idle. With the bit clear, every active source can wake the core, whether or not it is enabled. With the bit set, only enabled sources can.

Top module: `irq_router`

## Requirements
- R1: While reset is held, and on release, the enable, routing and control registers read 0. The IRQ, FIQ and wake outputs are 0 during reset.
- R2: Offset 0x10 returns the raw pending vector. This is the source lines captured at the most recent clock edge, regardless of enable or routing.
- R3: Offset 0x00 returns raw AND enable AND NOT routing. A routing bit of 0 selects IRQ for that source.
- R4: Offset 0x0C returns raw AND enable AND routing. A routing bit of 1 selects FIQ for that source.
- R5: `irqOut` is the OR of the IRQ-pending bits and `fiqOut` is the OR of the FIQ-pending bits. Both reflect register state after the last clock edge.
- R6: The enable register (0x04) and routing register (0x08) take the low source bits of a write. The control register (0x14) takes bit 0 only, as the idle-enable-override bit. All three read back what was written, zero-extended, from the cycle after the write.
- R7: Writes to offsets 0x00, 0x0C and 0x10 have no effect. The pending registers keep following the source lines only.
- R8: With `idleMode` high and control bit 0 clear, `wakeOut` is high whenever any raw pending bit is set, even if that source is disabled.
- R9: With `idleMode` high and control bit 0 set, `wakeOut` is high only when an enabled source is pending. That is the case exactly when `irqOut` or `fiqOut` is high.
- R10: `wakeOut` is 0 whenever `idleMode` is low.
- R11: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | NUM_SRC | Level-sensitive interrupt source lines |
| idleMode | input | 1 | High while the core is in idle |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Idle exit request to the mode sequencer |

## Verification
A source change or a register write shows up in the pending views and in `irqOut`/`fiqOut` one clock edge later. This is because the source lines and the configuration registers are both captured at that edge and the outputs are combinational from there. `wakeOut` additionally follows `idleMode` in the same cycle, and `rdData` follows `busAddr` in the same cycle. The bench drives inputs on the falling edge and lets one rising edge pass. Shortly after that edge it compares the three outputs, then steps the read address across every offset with small delays, all before the next rising edge. Between two edges nothing but the address changes.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

  localparam int OFF_IRQ_PEND = 'h00;
  localparam int OFF_ENABLE   = 'h04;
  localparam int OFF_ROUTE    = 'h08;
  localparam int OFF_FIQ_PEND = 'h0C;
  localparam int OFF_RAW_PEND = 'h10;
  localparam int OFF_CONTROL  = 'h14;

  typedef struct packed {
    logic wrEnable;
    logic wrRoute;
    logic wrControl;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IRQ,
    RD_ENABLE,
    RD_ROUTE,
    RD_FIQ,
    RD_RAW,
    RD_CONTROL
  } rd_sel_e;

endpackage

// File: rtl/irq_router_ctrl.sv
`timescale 1ns/1ps
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes,
  output rd_sel_e           rdSel
);

  always_comb begin
    rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFF_IRQ_PEND): rdSel = RD_IRQ;
      ADDR_W'(OFF_ENABLE):   rdSel = RD_ENABLE;
      ADDR_W'(OFF_ROUTE):    rdSel = RD_ROUTE;
      ADDR_W'(OFF_FIQ_PEND): rdSel = RD_FIQ;
      ADDR_W'(OFF_RAW_PEND): rdSel = RD_RAW;
      ADDR_W'(OFF_CONTROL):  rdSel = RD_CONTROL;
      default:               rdSel = RD_NONE;
    endcase
  end

  // Only the three configuration registers accept writes.
  always_comb begin
    strobes           = '0;
    strobes.wrEnable  = busWrEn && (rdSel == RD_ENABLE);
    strobes.wrRoute   = busWrEn && (rdSel == RD_ROUTE);
    strobes.wrControl = busWrEn && (rdSel == RD_CONTROL);
  end

endmodule

// File: rtl/irq_router_dp.sv
`timescale 1ns/1ps
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLines,
  input  logic               idleMode,
  input  strobe_t            strobes,
  input  rd_sel_e            rdSel,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] rawPend,
  output logic [NUM_SRC-1:0] enableVal,
  output logic [NUM_SRC-1:0] routeVal,
  output logic               idleOverride
);

  logic [NUM_SRC-1:0] irqPend;
  logic [NUM_SRC-1:0] fiqPend;
  logic               unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPend      <= '0;
      enableVal    <= '0;
      routeVal     <= '0;
      idleOverride <= 1'b0;
    end else begin
      rawPend <= srcLines;
      if (strobes.wrEnable)  enableVal    <= busWrData[NUM_SRC-1:0];
      if (strobes.wrRoute)   routeVal     <= busWrData[NUM_SRC-1:0];
      if (strobes.wrControl) idleOverride <= busWrData[0];
    end
  end

  // Per-source steering: enabled sources go to exactly one destination.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_steer
    logic qualified;
    assign qualified  = rawPend[s] & enableVal[s];
    assign irqPend[s] = qualified & ~routeVal[s];
    assign fiqPend[s] = qualified &  routeVal[s];
  end

  assign irqOut  = |irqPend;
  assign fiqOut  = |fiqPend;
  assign wakeOut = idleMode && (idleOverride ? (irqOut || fiqOut) : (|rawPend));

  always_comb begin
    case (rdSel)
      RD_IRQ:     rdData = DATA_W'(irqPend);
      RD_ENABLE:  rdData = DATA_W'(enableVal);
      RD_ROUTE:   rdData = DATA_W'(routeVal);
      RD_FIQ:     rdData = DATA_W'(fiqPend);
      RD_RAW:     rdData = DATA_W'(rawPend);
      RD_CONTROL: rdData = DATA_W'(idleOverride);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLines,
  input  logic               idleMode,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut
);

  strobe_t            strobes;
  rd_sel_e            rdSel;
  logic [NUM_SRC-1:0] rawPend;
  logic [NUM_SRC-1:0] enableVal;
  logic [NUM_SRC-1:0] routeVal;
  logic               idleOverride;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .srcLines     (srcLines),
    .idleMode     (idleMode),
    .strobes      (strobes),
    .rdSel        (rdSel),
    .busWrData    (busWrData),
    .rdData       (rdData),
    .irqOut       (irqOut),
    .fiqOut       (fiqOut),
    .wakeOut      (wakeOut),
    .rawPend      (rawPend),
    .enableVal    (enableVal),
    .routeVal     (routeVal),
    .idleOverride (idleOverride)
  );

endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcLines,
  input logic               idleMode,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] rawPend,
  input logic [NUM_SRC-1:0] enableVal,
  input logic [NUM_SRC-1:0] routeVal,
  input logic               idleOverride
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !fiqOut && enableVal == '0 && routeVal == '0 && !idleOverride)); // R1

  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rawPend == $past(srcLines)); // R2

  AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (routeVal == '1 || enableVal == '0) |-> !irqOut); // R3

  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (routeVal == '0 || enableVal == '0) |-> !fiqOut); // R4

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_W'('h04)) |=> $stable(enableVal)); // R7

  AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_W'('h08)) |=> $stable(routeVal)); // R7

  AST_WAKE_ANY: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && !idleOverride && rawPend != '0) |-> wakeOut); // R8

  AST_WAKE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && idleOverride) |-> (wakeOut == (irqOut || fiqOut))); // R9

  AST_WAKE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !idleMode |-> !wakeOut); // R10

endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .srcLines     (srcLines),
  .idleMode     (idleMode),
  .busWrEn      (busWrEn),
  .busAddr      (busAddr),
  .irqOut       (irqOut),
  .fiqOut       (fiqOut),
  .wakeOut      (wakeOut),
  .rawPend      (rawPend),
  .enableVal    (enableVal),
  .routeVal     (routeVal),
  .idleOverride (idleOverride)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

  localparam int NS = 24;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcLines = '0;
  logic          idleMode = 1'b0;
  logic          busWrEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] rdData;
  logic          irqOut, fiqOut, wakeOut;

  irq_router #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) i_irq_router (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .idleMode(idleMode),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut)
  );

  always #2 clk = ~clk;

  int  nChk = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  logic [NS-1:0] mSrc = '0, mEn = '0, mRoute = '0;
  logic          mOvr = 1'b0, mIdle = 1'b0;

  function automatic logic [DW-1:0] expRead(logic [AW-1:0] a);
    case (a)
      5'h00:   return DW'(mSrc & mEn & ~mRoute);
      5'h04:   return DW'(mEn);
      5'h08:   return DW'(mRoute);
      5'h0C:   return DW'(mSrc & mEn & mRoute);
      5'h10:   return DW'(mSrc);
      5'h14:   return DW'(mOvr);
      default: return '0;
    endcase
  endfunction

  function automatic logic expWake();
    if (!mIdle) return 1'b0;
    if (mOvr)   return |(mSrc & mEn);
    return |mSrc;
  endfunction

  function automatic string readTag(int k);
    case (k)
      0: return "R3";
      1: return "R6";
      2: return "R6";
      3: return "R4";
      4: return "R2";
      5: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [NS-1:0] src, logic idle, logic we,
                      logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    srcLines = src; idleMode = idle; busWrEn = we; busAddr = a; busWrData = d;
    @(posedge clk);
    #0.5;
    busWrEn = 1'b0;
    mSrc = src; mIdle = idle;
    if (we) begin
      case (a)
        5'h04: mEn    = d[NS-1:0];
        5'h08: mRoute = d[NS-1:0];
        5'h14: mOvr   = d[0];
        default: ;
      endcase
    end
    check({tag, "/R5 irq"}, DW'(irqOut), DW'(|(mSrc & mEn & ~mRoute)));
    check({tag, "/R5 fiq"}, DW'(fiqOut), DW'(|(mSrc & mEn & mRoute)));
    check({tag, mIdle ? (mOvr ? "/R9 wake" : "/R8 wake") : "/R10 wake"},
          DW'(wakeOut), DW'(expWake()));
    for (int k = 0; k < 8; k++) begin
      busAddr = AW'(k * 4);
      #0.3;
      check({tag, "/", readTag(k)}, rdData, expRead(busAddr));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R1: reset state with active sources and idle asserted
    srcLines = '1; idleMode = 1'b1;
    repeat (3) @(posedge clk);
    #0.5;
    check("R1 irq", DW'(irqOut), '0);
    check("R1 fiq", DW'(fiqOut), '0);
    check("R1 wake", DW'(wakeOut), '0);
    busAddr = 5'h04; #0.3; check("R1 enable", rdData, '0);
    busAddr = 5'h08; #0.3; check("R1 route", rdData, '0);
    busAddr = 5'h14; #0.3; check("R1 control", rdData, '0);
    @(negedge clk);
    rstN = 1'b1; srcLines = '0; idleMode = 1'b0;

    // R6: configuration writes
    step(24'h000001, 0, 1, 5'h04, 32'hFFFF_FFFF, "R6");
    step(24'h0000FF, 0, 1, 5'h08, 32'h0000_0F0F, "R6");
    step(24'h0000F0, 0, 1, 5'h14, 32'hFFFF_FFFF, "R6");
    step(24'h0000F0, 0, 1, 5'h14, 32'h0000_0000, "R6");
    // R7: writes to pending views are ignored
    step(24'h00A000, 0, 1, 5'h00, 32'hFFFF_FFFF, "R7");
    step(24'h00A000, 0, 1, 5'h0C, 32'hFFFF_FFFF, "R7");
    step(24'h000000, 0, 1, 5'h10, 32'hFFFF_FFFF, "R7");
    // R11: unmapped writes ignored
    step(24'h000000, 0, 1, 5'h18, 32'hFFFF_FFFF, "R11");
    step(24'h000000, 0, 1, 5'h1C, 32'hFFFF_FFFF, "R11");
    // R8: idle, override clear, everything disabled still wakes
    step(24'h000000, 1, 1, 5'h04, 32'h0, "R8");
    step(24'h800000, 1, 0, 5'h00, 32'h0, "R8");
    // R9: override set, disabled source does not wake, enabled does
    step(24'h800000, 1, 1, 5'h14, 32'h1, "R9");
    step(24'h800000, 1, 1, 5'h04, 32'h80_0000, "R9");
    step(24'h800000, 1, 1, 5'h08, 32'h80_0000, "R9");
    // R10: not idle
    step(24'hFFFFFF, 0, 1, 5'h04, 32'hFFFF_FFFF, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic we;
      a  = AW'(($urandom % 8) * 4);
      we = ($urandom % 10) < 4;
      step(NS'($urandom), 1'($urandom), we, a, $urandom, "RND");
    end
    step('0, 1, 0, 5'h00, 32'h0, "R2");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule